// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block derives horizontal and vertical video timing from a dot clock. A horizontal counter steps once per dot clock, and a vertical counter steps once per scanline. Both counters measure position from the leading (falling) edge of their sync pulse. Every edge the block produces is therefore an offset from sync start: the sync pulse width, the point where blanking begins and the point where blanking ends. Software programs the 12-bit timing registers through a simple write port. It reads back the live counters and the screen-refresh row address through a select-driven readback port.

The block produces active-low horizontal and vertical sync and active-low horizontal and vertical blank. It also produces a composite sync output that can either follow horizontal sync or combine both syncs. For genlock, either axis can take its reload event from an external sync input instead of its own wrap. When that external edge arrives, the counter is loaded from a programmable preload value. The block also keeps a refresh row address. This address steps once per displayed line and restarts at the top of vertical blanking from zero or from an alternate buffer base.

Top module: `raster_timing`

## Requirements
- R1: Horizontal counter (readback select 0) starts at 0 after reset and adds 1 per clock. In the clock after it equals `htotal`-1 (register address 0) it becomes `hpreload` (address 4) when the internal horizontal source is selected, and 0 otherwise.
- R2: Vertical counter (readback select 1) adds 1 at each line end. A line end is a horizontal terminal count or an accepted external horizontal edge. At a line end where it equals `vtotal`-1 (address 5) it becomes `vpreload` (address 9) under the internal vertical source, and 0 otherwise.
- R3: `hsync_n` is low exactly while hcount < `hsyncw` (address 1). `vsync_n` is low exactly while vcount < `vsyncw` (address 6).
- R4: Horizontal blank is active while hcount >= `hbstart` (address 3) or hcount < `hbend` (address 2). Vertical blank is active while vcount >= `vbstart` (address 8) or vcount < `vbend` (address 7). `hblank_n` and `vblank_n` are low while their blank is active.
- R5: The control register (address 11) bit 1 enables blanking. When this bit is 0, `hblank_n` and `vblank_n` are both held low.
- R6: When control bit 2 is 1, `csync_n` is the XNOR of `hsync_n` and `vsync_n`. When control bit 2 is 0, `csync_n` equals `hsync_n`.
- R7: Control bit 3 = 0 selects an external source for the horizontal axis, and control bit 4 = 0 does the same for the vertical axis. In external mode, a falling edge on that axis's sync input loads that counter with its preload value. The input is sampled by two synchroniser flops and an edge detector, so the loaded value appears after the third rising clock edge following the fall. A loaded horizontal edge also counts as a line end.
- R8: When control bits 3 and 4 are 1 (internal sources), the external sync inputs have no effect on either counter or on any output.
- R9: The refresh row address (readback select 2) takes a new base value in the clock after the state hcount = 0 and vcount = `vbstart`. The base is `altbase` (address 10) when control bit 0 is 1, and 0 otherwise. At other times it adds 1 in the clock after each state where hcount = `hbstart` and vertical blank is inactive.
- R10: After reset, both counters and the row address read 0, all timing registers are 0, and the control register is 5'b11010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..11) |
| wr_data | input | 12 | Register write data |
| rd_sel | input | 2 | Readback select: 0 hcount, 1 vcount, 2 row address |
| ext_hsync_n | input | 1 | External horizontal sync, active low, asynchronous |
| ext_vsync_n | input | 1 | External vertical sync, active low, asynchronous |
| rd_data | output | 12 | Readback value |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank_n | output | 1 | Horizontal blank, active low |
| vblank_n | output | 1 | Vertical blank, active low |
| csync_n | output | 1 | Composite or horizontal sync, active low |

## Verification
The hardest condition to reach is an external sync edge that lands in mid-line. The load must occur on a precise edge after the synchroniser, and the stimulus must also show that the same edge is ignored under internal sourcing. The bench runs several full frames in which every counter value, sync, blank and composite output is predicted arithmetically from the elapsed clock count. During an internally sourced frame it pulses both external inputs, and the prediction must still hold. In a separate run it selects external sourcing, drops each input at a chosen clock and reads the counter back after exactly three edges. The row address is followed by its own expected value from the first vertical-blank restart onward, with and without the alternate base.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  input  logic         ext_hsync_n,
  input  logic         ext_vsync_n,
  output logic [W-1:0] rd_data,
  output logic         hsync_n,
  output logic         vsync_n,
  output logic         hblank_n,
  output logic         vblank_n,
  output logic         csync_n
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [4:0] CTRL_RST = 5'b11010;

  logic [W-1:0] h_total, h_sw, h_be, h_bs, h_pre;
  logic [W-1:0] v_total, v_sw, v_be, v_bs, v_pre;
  logic [W-1:0] alt_base;
  logic [4:0]   ctrl;
  logic [W-1:0] hcount, vcount, row_addr;
  logic [2:0]   hs_sr, vs_sr;

  wire show_alt = ctrl[0];
  wire blank_en = ctrl[1];
  wire comp_en  = ctrl[2];
  wire int_h    = ctrl[3];
  wire int_v    = ctrl[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_total <= '0; h_sw <= '0; h_be <= '0; h_bs <= '0; h_pre <= '0;
      v_total <= '0; v_sw <= '0; v_be <= '0; v_bs <= '0; v_pre <= '0;
      alt_base <= '0;
      ctrl <= CTRL_RST;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0:  h_total  <= wr_data;
        4'd1:  h_sw     <= wr_data;
        4'd2:  h_be     <= wr_data;
        4'd3:  h_bs     <= wr_data;
        4'd4:  h_pre    <= wr_data;
        4'd5:  v_total  <= wr_data;
        4'd6:  v_sw     <= wr_data;
        4'd7:  v_be     <= wr_data;
        4'd8:  v_bs     <= wr_data;
        4'd9:  v_pre    <= wr_data;
        4'd10: alt_base <= wr_data;
        4'd11: ctrl     <= wr_data[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_sr <= 3'b111;
      vs_sr <= 3'b111;
    end else begin
      hs_sr <= {hs_sr[1:0], ext_hsync_n};
      vs_sr <= {vs_sr[1:0], ext_vsync_n};
    end
  end

  wire ext_hload = !int_h && hs_sr[2] && !hs_sr[1];
  wire ext_vload = !int_v && vs_sr[2] && !vs_sr[1];
  wire h_term    = (hcount == h_total - ONE);
  wire v_term    = (vcount == v_total - ONE);
  wire line_end  = h_term || ext_hload;

  wire h_in_blank = (hcount >= h_bs) || (hcount < h_be);
  wire v_in_blank = (vcount >= v_bs) || (vcount < v_be);

  always_ff @(posedge clk) begin
    if (!rst_n)          hcount <= '0;
    else if (ext_hload)  hcount <= h_pre;
    else if (h_term)     hcount <= int_h ? h_pre : '0;
    else                 hcount <= hcount + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          vcount <= '0;
    else if (ext_vload)  vcount <= v_pre;
    else if (line_end)   vcount <= v_term ? (int_v ? v_pre : '0) : vcount + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      row_addr <= '0;
    else if (hcount == '0 && vcount == v_bs)
      row_addr <= show_alt ? alt_base : '0;
    else if (hcount == h_bs && !v_in_blank)
      row_addr <= row_addr + ONE;
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = hcount;
      2'd1:    rd_data = vcount;
      2'd2:    rd_data = row_addr;
      default: rd_data = '0;
    endcase
  end

  assign hsync_n  = !(hcount < h_sw);
  assign vsync_n  = !(vcount < v_sw);
  assign hblank_n = blank_en && !h_in_blank;
  assign vblank_n = blank_en && !v_in_blank;
  assign csync_n  = comp_en ? !(hsync_n ^ vsync_n) : hsync_n;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] hcount,
  input logic [W-1:0] vcount,
  input logic [W-1:0] row_addr,
  input logic [W-1:0] h_total,
  input logic [W-1:0] h_pre,
  input logic [W-1:0] v_pre,
  input logic [W-1:0] alt_base,
  input logic         int_h,
  input logic         ext_hload,
  input logic         ext_vload,
  input logic         line_end,
  input logic         hsync_n
);
  AST_HWRAP_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_h && !ext_hload && hcount == h_total - W'(1)) |=> hcount == $past(h_pre)); // R1

  AST_VSTEP_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount != $past(vcount)) |-> ($past(line_end) || $past(ext_vload))); // R2

  AST_HSYNC_FALL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hsync_n) && !$past(wr_en)) |-> (hcount == '0 || hcount == $past(h_pre))); // R3

  AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hload |=> hcount == $past(h_pre)); // R7

  AST_EXT_VLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_vload |=> vcount == $past(v_pre)); // R7

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != $past(row_addr)) |->
      (row_addr == $past(row_addr) + W'(1) || row_addr == '0 || row_addr == $past(alt_base))); // R9
endmodule

bind raster_timing raster_timing_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .hcount(hcount), .vcount(vcount), .row_addr(row_addr),
  .h_total(h_total), .h_pre(h_pre), .v_pre(v_pre), .alt_base(alt_base),
  .int_h(int_h), .ext_hload(ext_hload), .ext_vload(ext_vload),
  .line_end(line_end), .hsync_n(hsync_n)
);

// File: tb/raster_timing_test.sv
`timescale 1ns/10ps
module raster_timing_test;
  localparam int HT = 20, HS = 3, HBE = 5, HBS = 16;
  localparam int VT = 12, VS = 2, VBE = 3, VBS = 10;
  localparam logic [11:0] BASE = 12'h123;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic ext_hsync_n = 1, ext_vsync_n = 1;
  logic [11:0] rd_data;
  logic hsync_n, vsync_n, hblank_n, vblank_n, csync_n;

  int n = 0, checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timing uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .ext_hsync_n(ext_hsync_n), .ext_vsync_n(ext_vsync_n),
    .rd_data(rd_data), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .hblank_n(hblank_n), .vblank_n(vblank_n), .csync_n(csync_n)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); n++;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 12'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic rd(int sel, output int val);
    rd_sel = 2'(sel); #0.2; val = int'(rd_data);
  endtask

  task automatic do_reset();
    rst_n = 0; ext_hsync_n = 1; ext_vsync_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; n = 0;
  endtask

  task automatic cfg(int ctrl);
    wr(0, HT); wr(5, VT); wr(1, HS); wr(2, HBE); wr(3, HBS);
    wr(6, VS); wr(7, VBE); wr(8, VBS); wr(10, BASE); wr(11, ctrl);
  endtask

  task automatic sweep(int cycles, bit comp, bit blank_en, bit alt, int pulse_at);
    bit known = 0;
    logic [11:0] erow = '0;
    int h, v, val;
    bit hs, vs, hbl, vbl;
    for (int i = 0; i < cycles; i++) begin
      h = n % HT; v = (n / HT) % VT;
      hs = !(h < HS); vs = !(v < VS);
      hbl = (h >= HBS) || (h < HBE);
      vbl = (v >= VBS) || (v < VBE);
      rd(0, val); chk("R1 hcount", val, h);
      rd(1, val); chk("R2 vcount", val, v);
      chk("R3 hsync_n", int'(hsync_n), int'(hs));
      chk("R3 vsync_n", int'(vsync_n), int'(vs));
      chk(blank_en ? "R4 hblank_n" : "R5 hblank_n", int'(hblank_n), int'(blank_en && !hbl));
      chk(blank_en ? "R4 vblank_n" : "R5 vblank_n", int'(vblank_n), int'(blank_en && !vbl));
      chk("R6 csync_n", int'(csync_n), comp ? int'(!(hs ^ vs)) : int'(hs));
      if (known) begin rd(2, val); chk("R9 row", val, int'(erow)); end
      if (h == 0 && v == VBS) begin erow = alt ? BASE : 12'd0; known = 1; end
      else if (h == HBS && !vbl) erow = erow + 12'd1;
      if (i == pulse_at) begin ext_hsync_n = 0; ext_vsync_n = 0; end  // R8 stimulus
      if (i == pulse_at + 5) begin ext_hsync_n = 1; ext_vsync_n = 1; end
      tick();
    end
  endtask

  initial begin
    #500us;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int val;
    @(negedge clk);
    do_reset();
    // R10 reset state
    rd(0, val); chk("R10 hcount", val, 0);
    rd(1, val); chk("R10 vcount", val, 0);
    rd(2, val); chk("R10 row", val, 0);
    chk("R10 hsync_n", int'(hsync_n), 1);
    chk("R10 hblank_n", int'(hblank_n), 0);
    chk("R10 csync_n", int'(csync_n), 1);

    // separate sync, buffer 0, external pulses ignored (R8)
    cfg(5'b11010);
    sweep(3 * HT * VT, 0, 1, 0, 300);

    // composite sync and alternate buffer base
    do_reset();
    cfg(5'b11111);
    sweep(2 * HT * VT, 1, 1, 1, -10);

    // blanking forced active
    do_reset();
    cfg(5'b11000);
    sweep(HT * VT + 40, 0, 0, 0, -10);

    // internal wrap loads the horizontal preload (R1)
    do_reset();
    wr(0, HT); wr(4, 3);
    while (n < 200) begin
      rd(0, val);
      chk("R1 preload wrap", val, (n < HT) ? n : 3 + (n - HT) % (HT - 3));
      tick();
    end

    // external horizontal then vertical reload (R7)
    do_reset();
    wr(0, HT); wr(5, VT); wr(4, 7); wr(9, 4); wr(11, 5'b10010);
    repeat (6) tick();
    ext_hsync_n = 0;
    repeat (3) tick();
    rd(0, val); chk("R7 ext hload", val, 7);
    repeat (4) tick();
    rd(0, val); chk("R7 count after hload", val, 11);
    ext_hsync_n = 1;
    wr(11, 5'b00010);
    repeat (4) tick();
    ext_vsync_n = 0;
    repeat (3) tick();
    rd(1, val); chk("R7 ext vload", val, 4);
    ext_vsync_n = 1;
    repeat (2) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule